// File: doc/BRIEF.md
# Rectangular Pixel Address Walker

This block produces the byte addresses of every pixel inside a rectangle that sits in a larger frame in memory. Software gives it a start address, the number of pixels in a line, the number of lines, a line skip counted in pixels, and a code for the pixel size. A one-cycle `start` while idle latches all of these values. The block then presents one address at a time on a valid/ready handshake, moves through each line pixel by pixel, and at the end of each line jumps over the skip to the first pixel of the next line.

Three copies of the block can run at once, one for each pixel stream of a blending engine: foreground read, background read and output write. For 4-bit pixels, two pixels share one byte. The `addrNibble` output tells the consumer which half of the byte holds the current pixel. The block gives a one-cycle watermark pulse after the last pixel of a chosen line, and a one-cycle done pulse after the last pixel of the rectangle. It refuses to start when the configuration is illegal and flags that instead. An abort input drops a transfer at once.

Top module: `pix_addr_walker`

## Requirements
- R1: Right after reset, `addrValid`, `busy`, `done`, `watermark` and `cfgError` are all low.
- R2: A `start` pulse while idle, with a legal configuration and a nonzero size, makes `busy` and `addrValid` high in the next cycle. In that cycle `addrOut` equals `baseAddr` and `addrNibble` is 0.
- R3: The `pixSize` codes are: 0 = 4 bytes, 1 = 3 bytes, 2 = 2 bytes, 3 = 4 bits. After each accepted address (`addrValid` and `addrReady` high together) inside a line, the address moves on by one pixel. For code 3 it moves by half a byte: `addrNibble` alternates 0,1 and `addrOut` rises by one byte every second pixel.
- R4: After the last pixel of a line, the next address is the one just past that pixel plus `lineSkip` times the pixel size.
- R5: A `start` while idle raises `cfgError` for exactly the next cycle and starts nothing when the configuration is illegal. Illegal means any of the following:
  - code 0 and `baseAddr[1:0]` nonzero;
  - code 2 and `baseAddr[0]` set;
  - code 3 and either `linePixels` or `lineSkip` odd.
- R6: While `addrValid` is high and `addrReady` is low, `addrOut` and `addrNibble` hold their values.
- R7: `watermark` pulses for one cycle, in the cycle after the last pixel of line number `wmLine` is accepted. Lines are counted from 0. If `wmLine` is not below the line count, there is no pulse.
- R8: `done` pulses for one cycle, in the cycle after the final pixel is accepted. In that cycle `busy` and `addrValid` are low.
- R9: `abort` while busy makes `busy` and `addrValid` low in the next cycle, with no `done` pulse. `abort` takes priority over a handshake in the same cycle.
- R10: A `start` with zero lines or zero pixels per line pulses `done` in the next cycle and issues no address.
- R11: Configuration inputs and `start` are ignored while busy. The running rectangle keeps the values latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| abort | input | 1 | Drop the running transfer |
| baseAddr | input | 32 | Byte address of the first pixel |
| linePixels | input | 14 | Pixels per line |
| numLines | input | 16 | Number of lines |
| lineSkip | input | 14 | Pixels skipped between lines |
| pixSize | input | 2 | Pixel size code (see R3) |
| wmLine | input | 16 | Line number for the watermark pulse |
| addrValid | output | 1 | An address is offered |
| addrReady | input | 1 | Consumer takes the offered address |
| addrOut | output | 32 | Byte address of the current pixel |
| addrNibble | output | 1 | Upper half of the byte (4-bit pixels only) |
| busy | output | 1 | Transfer in progress |
| watermark | output | 1 | Watermark line finished (pulse) |
| done | output | 1 | Rectangle finished (pulse) |
| cfgError | output | 1 | Start refused due to illegal configuration (pulse) |

## Verification
Four rectangles cover every pixel size code. Each uses different widths, heights and skips, so a wrong step size, a skip counted in bytes instead of pixels, or a misplaced line wrap gives a different address sequence. The 4-bit rectangle separates nibble stepping from byte stepping, and one rectangle puts the watermark past the last line. The consumer's ready is irregular, which exposes addresses that move while stalled. A rectangle whose inputs are changed and restarted mid-run shows whether the latched values are held. Separate starts with misaligned bases, odd 4-bit sizes, zero lines and an abort cover the refusal and early-exit paths.

// File: rtl/paw_pkg.sv
package paw_pkg;
  typedef struct packed {
    logic load;     // capture configuration
    logic step;     // one pixel accepted
    logic lineEnd;  // the accepted pixel closes its line
  } pawStrobe_t;

  localparam logic [1:0] SZ_WORD   = 2'd0;
  localparam logic [1:0] SZ_TRIPLE = 2'd1;
  localparam logic [1:0] SZ_HALF   = 2'd2;
  localparam logic [1:0] SZ_NIBBLE = 2'd3;

  // pixel size in half-bytes
  function automatic logic [3:0] nibbleStep(input logic [1:0] code);
    case (code)
      SZ_WORD:   nibbleStep = 4'd8;
      SZ_TRIPLE: nibbleStep = 4'd6;
      SZ_HALF:   nibbleStep = 4'd4;
      default:   nibbleStep = 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/paw_ctrl.sv
module paw_ctrl
  import paw_pkg::*;
#(
  parameter int PPL_W  = 14,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic              cfgBad,
  input  logic [PPL_W-1:0]  linePixels,
  input  logic [LINE_W-1:0] numLines,
  input  logic [LINE_W-1:0] wmLine,
  input  logic              addrReady,
  output pawStrobe_t        strobe,
  output logic              addrValid,
  output logic              busy,
  output logic              watermark,
  output logic              done,
  output logic              cfgError
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t            state;
  logic [PPL_W-1:0]  pplQ, pixCnt;
  logic [LINE_W-1:0] linesQ, wmQ, lineCnt;
  logic              fire, lastPix, lastLine, launch, emptyJob;

  assign fire     = (state == ST_RUN) && addrReady && !abort;
  assign lastPix  = (pixCnt + PPL_W'(1)) == pplQ;
  assign lastLine = (lineCnt + LINE_W'(1)) == linesQ;
  assign emptyJob = (linePixels == '0) || (numLines == '0);
  assign launch   = (state == ST_IDLE) && start && !cfgBad && !emptyJob;

  assign strobe.load    = launch;
  assign strobe.step    = fire;
  assign strobe.lineEnd = fire && lastPix;

  assign addrValid = (state == ST_RUN);
  assign busy      = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pplQ      <= '0;
      linesQ    <= '0;
      wmQ       <= '0;
      pixCnt    <= '0;
      lineCnt   <= '0;
      watermark <= 1'b0;
      done      <= 1'b0;
      cfgError  <= 1'b0;
    end else begin
      watermark <= 1'b0;
      done      <= 1'b0;
      cfgError  <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          if (cfgBad) begin
            cfgError <= 1'b1;
          end else if (emptyJob) begin
            done <= 1'b1;
          end else begin
            state   <= ST_RUN;
            pplQ    <= linePixels;
            linesQ  <= numLines;
            wmQ     <= wmLine;
            pixCnt  <= '0;
            lineCnt <= '0;
          end
        end
      end else if (abort) begin
        state <= ST_IDLE;
      end else if (fire) begin
        if (lastPix) begin
          pixCnt <= '0;
          if (lineCnt == wmQ) watermark <= 1'b1;
          if (lastLine) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            lineCnt <= lineCnt + LINE_W'(1);
          end
        end else begin
          pixCnt <= pixCnt + PPL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/paw_dpath.sv
module paw_dpath
  import paw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PPL_W  = 14,
  parameter int OFF_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  pawStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [PPL_W-1:0]  linePixels,
  input  logic [OFF_W-1:0]  lineSkip,
  input  logic [1:0]        pixSize,
  output logic              cfgBad,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrNibble
);
  localparam int NIB_W  = ADDR_W + 1;
  localparam int SKIP_W = OFF_W + 4;

  logic [NIB_W-1:0]  pos;
  logic [3:0]        stepQ;
  logic [SKIP_W-1:0] skipQ;
  logic [3:0]        stepNow;

  assign stepNow = nibbleStep(pixSize);

  always_comb begin
    case (pixSize)
      SZ_WORD:   cfgBad = (baseAddr[1:0] != 2'b00);
      SZ_HALF:   cfgBad = baseAddr[0];
      SZ_NIBBLE: cfgBad = linePixels[0] | lineSkip[0];
      default:   cfgBad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos   <= '0;
      stepQ <= '0;
      skipQ <= '0;
    end else if (strobe.load) begin
      pos   <= {baseAddr, 1'b0};
      stepQ <= stepNow;
      skipQ <= SKIP_W'(lineSkip) * SKIP_W'(stepNow);
    end else if (strobe.step) begin
      pos <= pos + NIB_W'(stepQ) + (strobe.lineEnd ? NIB_W'(skipQ) : NIB_W'(0));
    end
  end

  assign addrOut    = pos[NIB_W-1:1];
  assign addrNibble = pos[0];
endmodule

// File: rtl/pix_addr_walker.sv
module pix_addr_walker
  import paw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PPL_W  = 14,
  parameter int LINE_W = 16,
  parameter int OFF_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [PPL_W-1:0]  linePixels,
  input  logic [LINE_W-1:0] numLines,
  input  logic [OFF_W-1:0]  lineSkip,
  input  logic [1:0]        pixSize,
  input  logic [LINE_W-1:0] wmLine,
  output logic              addrValid,
  input  logic              addrReady,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrNibble,
  output logic              busy,
  output logic              watermark,
  output logic              done,
  output logic              cfgError
);
  pawStrobe_t strobe;
  logic       cfgBad;

  paw_ctrl #(.PPL_W(PPL_W), .LINE_W(LINE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .cfgBad(cfgBad),
    .linePixels(linePixels), .numLines(numLines), .wmLine(wmLine),
    .addrReady(addrReady), .strobe(strobe), .addrValid(addrValid),
    .busy(busy), .watermark(watermark), .done(done), .cfgError(cfgError)
  );

  paw_dpath #(.ADDR_W(ADDR_W), .PPL_W(PPL_W), .OFF_W(OFF_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .linePixels(linePixels), .lineSkip(lineSkip), .pixSize(pixSize),
    .cfgBad(cfgBad), .addrOut(addrOut), .addrNibble(addrNibble)
  );
endmodule

// File: rtl/paw_checker.sv
module paw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              abort,
  input logic              addrValid,
  input logic              addrReady,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrNibble,
  input logic              busy,
  input logic              watermark,
  input logic              done,
  input logic              cfgError
);
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !addrReady && !abort |=> addrValid && $stable(addrOut) && $stable(addrNibble));

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    busy && abort |=> !busy && !addrValid && !done);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !addrValid ##1 !done);

  a_r7_wm_pulse: assert property (@(posedge clk) disable iff (!rstN)
    watermark |=> !watermark);

  a_r5_cfgerr_idle: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !busy && !done);
endmodule

bind pix_addr_walker paw_checker #(.ADDR_W(ADDR_W)) uPawChk (
  .clk(clk), .rstN(rstN), .abort(abort), .addrValid(addrValid),
  .addrReady(addrReady), .addrOut(addrOut), .addrNibble(addrNibble),
  .busy(busy), .watermark(watermark), .done(done), .cfgError(cfgError)
);

// File: tb/tb_pix_addr_walker.sv
`timescale 1ns/1ps
module tb_pix_addr_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, abort = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [13:0] linePixels = '0, lineSkip = '0;
  logic [15:0] numLines = '0, wmLine = '0;
  logic [1:0]  pixSize = '0;
  logic        addrReady = 1'b0;
  logic        addrValid, addrNibble, busy, watermark, done, cfgError;
  logic [31:0] addrOut;

  int checks = 0, errors = 0;
  logic [32:0] expQ[$];
  int popCnt = 0, expWmAt = -1, doneCnt = 0, wmCnt = 0;
  logic forceStall = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic prevStall = 1'b0;
  logic [31:0] prevAddr = '0;
  logic prevNib = 1'b0;

  always #2 clk = ~clk;

  pix_addr_walker dut (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .baseAddr(baseAddr),
    .linePixels(linePixels), .numLines(numLines), .lineSkip(lineSkip),
    .pixSize(pixSize), .wmLine(wmLine), .addrValid(addrValid),
    .addrReady(addrReady), .addrOut(addrOut), .addrNibble(addrNibble),
    .busy(busy), .watermark(watermark), .done(done), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: drives ready, compares handshaked addresses
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check(addrOut == prevAddr && addrNibble == prevNib, "R6 stall hold", {addrOut, 31'b0, addrNibble}, {prevAddr, 31'b0, prevNib});
      if (watermark) begin
        wmCnt++;
        check(popCnt == expWmAt, "R7 watermark position", popCnt, expWmAt);
      end
      if (done) begin
        doneCnt++;
        check(expQ.size() == 0 && !busy, "R8 done after last pixel", expQ.size(), 0);
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      addrReady = !forceStall && (lfsr[1:0] != 2'b00);
      prevStall = addrValid && !addrReady;
      prevAddr  = addrOut;
      prevNib   = addrNibble;
      if (addrValid && addrReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected address", addrOut, 0);
        end else begin
          logic [32:0] e;
          e = expQ.pop_front();
          popCnt++;
          check(addrOut == e[32:1] && addrNibble == e[0], "R3/R4 address sequence",
                {addrOut, 31'b0, addrNibble}, {e[32:1], 31'b0, e[0]});
        end
      end
    end
  end

  function automatic int stepOf(input logic [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 6; 2'd2: return 4; default: return 1; endcase
  endfunction

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic runFrame(input logic [31:0] b, input int ppl, input int nl, input int off,
                          input logic [1:0] c, input int wm, input bit mutate);
    int st, d0, w0;
    st = stepOf(c);
    for (int l = 0; l < nl; l++)
      for (int p = 0; p < ppl; p++)
        expQ.push_back(33'({b, 1'b0}) + 33'(l * (ppl + off) * st) + 33'(p * st));
    popCnt = 0;
    expWmAt = (wm < nl) ? (wm + 1) * ppl : -1;
    d0 = doneCnt; w0 = wmCnt;
    baseAddr = b; linePixels = 14'(ppl); numLines = 16'(nl);
    lineSkip = 14'(off); pixSize = c; wmLine = 16'(wm);
    pulseStart();
    check(busy && addrValid, "R2 busy after start", {busy, addrValid}, 2'b11);
    if (mutate) begin
      // R11: new values and a second start during the run must be ignored
      baseAddr = 32'hDEAD_0000; linePixels = 14'd1; numLines = 16'd1;
      lineSkip = 14'd7; pixSize = 2'd2; wmLine = 16'd0;
      pulseStart();
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(doneCnt == d0 + 1, "R8 one done pulse", doneCnt - d0, 1);
    check(wmCnt == w0 + ((wm < nl) ? 1 : 0), "R7 watermark count", wmCnt - w0, (wm < nl) ? 1 : 0);
    check(expQ.size() == 0, "R11 all addresses issued", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!addrValid && !busy && !done && !watermark && !cfgError, "R1 reset state",
          {addrValid, busy, done, watermark, cfgError}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runFrame(32'h0000_1000, 3, 3, 2, 2'd0, 1, 1'b0);  // R3 R4 R7 32-bit
    runFrame(32'h0000_2002, 4, 2, 5, 2'd2, 0, 1'b0);  // 16-bit, watermark on line 0
    runFrame(32'h0000_3001, 5, 2, 1, 2'd1, 7, 1'b0);  // 24-bit, no watermark
    runFrame(32'h0000_4001, 6, 3, 4, 2'd3, 2, 1'b0);  // 4-bit nibble stepping
    runFrame(32'h0000_5000, 4, 3, 3, 2'd0, 2, 1'b1);  // R11 mutation

    // R5 illegal configurations
    baseAddr = 32'h0000_6002; pixSize = 2'd0; linePixels = 14'd4; numLines = 16'd2; lineSkip = 14'd0;
    pulseStart();
    check(cfgError && !busy, "R5 misaligned 32-bit", {cfgError, busy}, 2'b10);
    @(negedge clk);
    check(!cfgError && !busy, "R5 single-cycle flag", {cfgError, busy}, 2'b00);
    baseAddr = 32'h0000_6001; pixSize = 2'd2;
    pulseStart();
    check(cfgError && !busy, "R5 misaligned 16-bit", {cfgError, busy}, 2'b10);
    baseAddr = 32'h0000_6000; pixSize = 2'd3; linePixels = 14'd5;
    pulseStart();
    check(cfgError && !busy, "R5 odd 4-bit line", {cfgError, busy}, 2'b10);
    linePixels = 14'd4; lineSkip = 14'd3;
    pulseStart();
    check(cfgError && !busy, "R5 odd 4-bit skip", {cfgError, busy}, 2'b10);

    // R10 zero size
    pixSize = 2'd0; lineSkip = 14'd0; numLines = 16'd0;
    pulseStart();
    check(done && !busy && !addrValid, "R10 zero lines", {done, busy, addrValid}, 3'b100);
    numLines = 16'd3; linePixels = 14'd0;
    pulseStart();
    check(done && !busy && !addrValid, "R10 zero pixels", {done, busy, addrValid}, 3'b100);

    // R9 abort while stalled
    forceStall = 1'b1;
    @(negedge clk);
    baseAddr = 32'h0000_7000; linePixels = 14'd8; numLines = 16'd4; wmLine = 16'd0;
    pulseStart();
    check(addrValid && addrOut == 32'h7000 && !addrNibble, "R2 first address", addrOut, 32'h7000);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(!busy && !addrValid && !done, "R9 abort to idle", {busy, addrValid, done}, 0);
    @(negedge clk);
    check(!done, "R9 no done after abort", done, 0);
    forceStall = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule